// File: doc/BRIEF.md
# Vector Memory Access Sequencer

This block takes a single vector load or store instruction and breaks it into a run of memory requests, each as wide as the memory data path. The number of requests is the vector register width divided by the memory data width. With the default parameters (a 256-bit vector and a 32-bit memory path) that is eight requests. Requests go out one per cycle through a valid/ready handshake toward a downstream load/store pipeline. Each request carries its own index, and the address of a request is the base address plus the index times the access width in bytes. This gives unit-stride access only.

Every response names the request it answers. The block keeps one completion bit per request, apart from the instruction as a whole, so responses may come back in any order. For a load, each response is placed in its slot of a full-width gather buffer. The vector destination is then written back once, in a single cycle, only after every slot has been filled. For a store, each request carries the matching slice of the source vector, and completion is reported by a single-cycle done pulse with no writeback. Only one instruction is handled at a time. The input ready stays low until the current instruction has fully completed.

Top module: `vmem_sequencer`

## Requirements
- R1: After a synchronous active-high reset, instReady is 1 and reqValid, wbValid and storeDone are 0.
- R2: An accepted instruction produces exactly NUM_REQ = VLEN/MEM_W requests, with reqIdx running 0, 1, ... NUM_REQ-1 in that order.
- R3: The address of request i is the latched base plus i*(MEM_W/8), modulo 2^ADDR_W.
- R4: While reqReady is held high, one request is accepted on every cycle, so all NUM_REQ requests go out in NUM_REQ consecutive cycles. While reqReady is low, the pending request holds its index and contents.
- R5: instReady is 0 from the cycle after an instruction is accepted until the instruction completes. An instValid presented during that time is ignored and has no effect on the requests issued.
- R6: reqIsStore is 1 for a store and 0 for a load. For a store, the reqWdata of request i equals bits [i*MEM_W +: MEM_W] of the source vector latched at acceptance.
- R7: A load response with rspIdx = i writes rspData into bits [i*MEM_W +: MEM_W] of wbData, whatever the order in which responses arrive.
- R8: For a load, wbValid is 0 until every request has its response. It is then 1 for exactly one cycle, in the cycle after the last response, with wbDest equal to the destination tag latched at acceptance.
- R9: For a store, storeDone is 1 for exactly one cycle, in the cycle after the last response, and wbValid stays 0.
- R10: A reset applied in the middle of an instruction abandons it: in the next cycle instReady is 1 and reqValid is 0, and a following instruction runs normally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| instValid | input | 1 | A vector instruction is offered |
| instReady | output | 1 | The sequencer is idle and will take an instruction |
| instIsStore | input | 1 | 1 for a store, 0 for a load |
| instBase | input | ADDR_W | Base byte address |
| instDest | input | DEST_W | Destination register tag for loads |
| instStoreData | input | VLEN | Source vector for stores |
| reqValid | output | 1 | A memory request is offered |
| reqReady | input | 1 | The pipeline accepts the request |
| reqIsStore | output | 1 | The request is a store |
| reqIdx | output | IDX_W | Index of the request within the instruction |
| reqAddr | output | ADDR_W | Byte address of the request |
| reqWdata | output | MEM_W | Store slice for the request |
| rspValid | input | 1 | A request has completed |
| rspIdx | input | IDX_W | Index of the completed request |
| rspData | input | MEM_W | Load data for the completed request |
| wbValid | output | 1 | Single-cycle full-vector writeback |
| wbDest | output | DEST_W | Destination tag of the writeback |
| wbData | output | VLEN | Gathered vector |
| storeDone | output | 1 | Single-cycle store completion pulse |

## Verification
The hardest situation to reach from the ports is a completion bitmap filled in scrambled order while the pipeline stalls at uneven intervals and a second instruction is waiting at the input. The stimulus gets there by holding instValid high with conflicting contents during the whole issue phase. It also throttles reqReady in a repeating pattern and returns responses in a stride permutation of the indices. After that, it checks that no extra request appears, that no writeback or done pulse appears early, and that each gathered slice lands in its own slot.

// File: rtl/vseq_pkg.sv
package vseq_pkg;
  typedef struct packed {
    logic load;     // latch a new instruction, clear completion state
    logic advance;  // a request was accepted downstream
    logic finish;   // all requests completed this cycle
  } seqStrobe_t;
endpackage

// File: rtl/vseq_ctrl.sv
module vseq_ctrl
  import vseq_pkg::*;
#(
  parameter int NUM_REQ = 8,
  parameter int IDX_W   = 3,
  parameter int CNT_W   = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             instValid,
  output logic             instReady,
  input  logic             instIsStore,
  output logic             reqValid,
  input  logic             reqReady,
  output logic             reqIsStore,
  output logic [IDX_W-1:0] reqIdx,
  input  logic             rspValid,
  input  logic             allDone,
  output seqStrobe_t       strobe,
  output logic             wbValid,
  output logic             storeDone
);
  logic             busy;
  logic             storeMode;
  logic [CNT_W-1:0] issueCnt;
  logic             issuing;

  assign issuing    = busy && (issueCnt < CNT_W'(NUM_REQ));
  assign instReady  = !busy;
  assign reqValid   = issuing;
  assign reqIdx     = issueCnt[IDX_W-1:0];
  assign reqIsStore = storeMode;

  assign strobe.load    = instValid && !busy;
  assign strobe.advance = issuing && reqReady;
  assign strobe.finish  = busy && allDone;

  assign wbValid   = strobe.finish && !storeMode;
  assign storeDone = strobe.finish && storeMode;

  always_ff @(posedge clk) begin
    if (rst) begin
      busy      <= 1'b0;
      storeMode <= 1'b0;
      issueCnt  <= '0;
    end else if (strobe.load) begin
      busy      <= 1'b1;
      storeMode <= instIsStore;
      issueCnt  <= '0;
    end else begin
      if (strobe.advance) issueCnt <= issueCnt + 1'b1;
      if (strobe.finish)  busy     <= 1'b0;
    end
  end

  AST_IDLE_NO_REQ: assert property (@(posedge clk) disable iff (rst)
    instReady |-> !reqValid) else $error("idle sequencer issued a request"); // R5

  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (rst)
    (reqValid && !reqReady) |=> (reqValid && $stable(reqIdx))) else $error("stalled request changed"); // R4

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (rst)
    (wbValid || storeDone) |=> !(wbValid || storeDone)) else $error("completion longer than a cycle"); // R8

  AST_NO_RSP_IDLE: assert property (@(posedge clk) disable iff (rst)
    rspValid |-> busy) else $error("response with no instruction in flight"); // R7

  AST_REQ_IN_RANGE: assert property (@(posedge clk) disable iff (rst)
    reqValid |-> (CNT_W'(reqIdx) < CNT_W'(NUM_REQ))) else $error("request index out of range"); // R2
endmodule

// File: rtl/vseq_datapath.sv
module vseq_datapath
  import vseq_pkg::*;
#(
  parameter int VLEN    = 256,
  parameter int MEM_W   = 32,
  parameter int ADDR_W  = 32,
  parameter int DEST_W  = 5,
  parameter int NUM_REQ = 8,
  parameter int IDX_W   = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  seqStrobe_t        strobe,
  input  logic [ADDR_W-1:0] instBase,
  input  logic [DEST_W-1:0] instDest,
  input  logic [VLEN-1:0]   instStoreData,
  input  logic [IDX_W-1:0]  reqIdx,
  output logic [ADDR_W-1:0] reqAddr,
  output logic [MEM_W-1:0]  reqWdata,
  input  logic              rspValid,
  input  logic [IDX_W-1:0]  rspIdx,
  input  logic [MEM_W-1:0]  rspData,
  output logic              allDone,
  output logic [DEST_W-1:0] wbDest,
  output logic [VLEN-1:0]   wbData
);
  localparam int BYTES = MEM_W / 8;

  logic [ADDR_W-1:0]                 baseReg;
  logic [DEST_W-1:0]                 destReg;
  logic [NUM_REQ-1:0][MEM_W-1:0]     storeVec;
  logic [NUM_REQ-1:0][MEM_W-1:0]     gatherBuf;
  logic [NUM_REQ-1:0]                doneMap;

  always_ff @(posedge clk) begin
    if (rst) begin
      baseReg  <= '0;
      destReg  <= '0;
      storeVec <= '0;
    end else if (strobe.load) begin
      baseReg  <= instBase;
      destReg  <= instDest;
      storeVec <= instStoreData;
    end
  end

  assign reqAddr  = baseReg + (ADDR_W'(reqIdx) * ADDR_W'(BYTES));
  assign reqWdata = storeVec[reqIdx];

  for (genvar g = 0; g < NUM_REQ; g++) begin : gSlot
    logic hit;
    assign hit = rspValid && (rspIdx == IDX_W'(g));

    always_ff @(posedge clk) begin
      if (rst || strobe.load) doneMap[g] <= 1'b0;
      else if (hit)           doneMap[g] <= 1'b1;
    end

    always_ff @(posedge clk) begin
      if (rst)      gatherBuf[g] <= '0;
      else if (hit) gatherBuf[g] <= rspData;
    end
  end

  assign allDone = &doneMap;
  assign wbDest  = destReg;
  assign wbData  = gatherBuf;

  AST_RSP_ONCE: assert property (@(posedge clk) disable iff (rst)
    rspValid |-> !doneMap[rspIdx]) else $error("request completed twice"); // R7

  AST_LOAD_CLEARS: assert property (@(posedge clk) disable iff (rst)
    strobe.load |=> (doneMap == '0)) else $error("completion map not cleared"); // R8
endmodule

// File: rtl/vmem_sequencer.sv
module vmem_sequencer
  import vseq_pkg::*;
#(
  parameter int VLEN   = 256,
  parameter int MEM_W  = 32,
  parameter int ADDR_W = 32,
  parameter int DEST_W = 5,
  localparam int NUM_REQ = VLEN / MEM_W,
  localparam int IDX_W   = (NUM_REQ > 1) ? $clog2(NUM_REQ) : 1,
  localparam int CNT_W   = $clog2(NUM_REQ + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              instValid,
  output logic              instReady,
  input  logic              instIsStore,
  input  logic [ADDR_W-1:0] instBase,
  input  logic [DEST_W-1:0] instDest,
  input  logic [VLEN-1:0]   instStoreData,
  output logic              reqValid,
  input  logic              reqReady,
  output logic              reqIsStore,
  output logic [IDX_W-1:0]  reqIdx,
  output logic [ADDR_W-1:0] reqAddr,
  output logic [MEM_W-1:0]  reqWdata,
  input  logic              rspValid,
  input  logic [IDX_W-1:0]  rspIdx,
  input  logic [MEM_W-1:0]  rspData,
  output logic              wbValid,
  output logic [DEST_W-1:0] wbDest,
  output logic [VLEN-1:0]   wbData,
  output logic              storeDone
);
  seqStrobe_t strobe;
  logic       allDone;

  vseq_ctrl #(
    .NUM_REQ(NUM_REQ), .IDX_W(IDX_W), .CNT_W(CNT_W)
  ) u_ctrl (
    .clk(clk), .rst(rst),
    .instValid(instValid), .instReady(instReady), .instIsStore(instIsStore),
    .reqValid(reqValid), .reqReady(reqReady), .reqIsStore(reqIsStore), .reqIdx(reqIdx),
    .rspValid(rspValid), .allDone(allDone), .strobe(strobe),
    .wbValid(wbValid), .storeDone(storeDone)
  );

  vseq_datapath #(
    .VLEN(VLEN), .MEM_W(MEM_W), .ADDR_W(ADDR_W), .DEST_W(DEST_W),
    .NUM_REQ(NUM_REQ), .IDX_W(IDX_W)
  ) u_dp (
    .clk(clk), .rst(rst), .strobe(strobe),
    .instBase(instBase), .instDest(instDest), .instStoreData(instStoreData),
    .reqIdx(reqIdx), .reqAddr(reqAddr), .reqWdata(reqWdata),
    .rspValid(rspValid), .rspIdx(rspIdx), .rspData(rspData),
    .allDone(allDone), .wbDest(wbDest), .wbData(wbData)
  );
endmodule

// File: tb/vmem_sequencer_tb.sv
module vmem_sequencer_tb;
  localparam int VLEN = 256, MEM_W = 32, ADDR_W = 32, DEST_W = 5;
  localparam int N = VLEN / MEM_W;
  localparam int IW = $clog2(N);

  logic clk = 0, rst = 1;
  logic instValid = 0, instIsStore = 0, reqReady = 0, rspValid = 0;
  logic [ADDR_W-1:0] instBase = '0;
  logic [DEST_W-1:0] instDest = '0;
  logic [VLEN-1:0]   instStoreData = '0;
  logic [IW-1:0]     rspIdx = '0;
  logic [MEM_W-1:0]  rspData = '0;
  logic instReady, reqValid, reqIsStore, wbValid, storeDone;
  logic [IW-1:0]     reqIdx;
  logic [ADDR_W-1:0] reqAddr;
  logic [MEM_W-1:0]  reqWdata;
  logic [DEST_W-1:0] wbDest;
  logic [VLEN-1:0]   wbData;

  int tests = 0, fails = 0;

  typedef struct {
    logic [ADDR_W-1:0] addr;
    logic [IW-1:0]     idx;
    logic              st;
    logic [MEM_W-1:0]  wd;
  } expReq_t;
  expReq_t expQ[$];

  always #5 clk = ~clk;

  vmem_sequencer #(.VLEN(VLEN), .MEM_W(MEM_W), .ADDR_W(ADDR_W), .DEST_W(DEST_W)) u_dut (
    .clk(clk), .rst(rst), .instValid(instValid), .instReady(instReady),
    .instIsStore(instIsStore), .instBase(instBase), .instDest(instDest),
    .instStoreData(instStoreData), .reqValid(reqValid), .reqReady(reqReady),
    .reqIsStore(reqIsStore), .reqIdx(reqIdx), .reqAddr(reqAddr), .reqWdata(reqWdata),
    .rspValid(rspValid), .rspIdx(rspIdx), .rspData(rspData), .wbValid(wbValid),
    .wbDest(wbDest), .wbData(wbData), .storeDone(storeDone)
  );

  task automatic check(input bit ok, input string req, input logic [VLEN-1:0] act,
                       input logic [VLEN-1:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // monitor: compare each accepted request against the scoreboard
  always @(negedge clk) begin
    if (!rst && reqValid && reqReady) begin
      if (expQ.size() == 0) begin
        check(1'b0, "R2 extra request", VLEN'(reqIdx), '0);
      end else begin
        expReq_t e;
        e = expQ.pop_front();
        check(reqIdx == e.idx, "R2 index", VLEN'(reqIdx), VLEN'(e.idx));
        check(reqAddr == e.addr, "R3 address", VLEN'(reqAddr), VLEN'(e.addr));
        check(reqIsStore == e.st, "R6 kind", VLEN'(reqIsStore), VLEN'(e.st));
        if (e.st) check(reqWdata == e.wd, "R6 store slice", VLEN'(reqWdata), VLEN'(e.wd));
      end
    end
  end

  task automatic runInst(input bit st, input logic [ADDR_W-1:0] base,
                         input logic [DEST_W-1:0] dest, input logic [VLEN-1:0] data,
                         input bit stall, input int off);
    int cycles;
    @(posedge clk); #1;
    check(instReady == 1'b1, "R5 ready before start", VLEN'(instReady), 1);
    instValid = 1; instIsStore = st; instBase = base; instDest = dest; instStoreData = data;
    for (int i = 0; i < N; i++)
      expQ.push_back('{base + ADDR_W'(i * (MEM_W / 8)), IW'(i), st, data[i*MEM_W +: MEM_W]});
    @(posedge clk); #1;
    // keep offering a conflicting instruction while busy
    instBase = 32'hDEAD0000; instIsStore = !st; instStoreData = '1; instDest = ~dest;
    cycles = 0;
    forever begin
      if (expQ.size() == 0) break;
      cycles++;
      reqReady = stall ? (cycles % 3 != 0) : 1'b1;
      @(negedge clk);
      if (cycles == 1) check(instReady == 1'b0, "R5 busy", VLEN'(instReady), 0);
      @(posedge clk); #1;
      if (cycles > 200) break;
    end
    if (!stall) check(cycles == N, "R4 back-to-back", VLEN'(cycles), VLEN'(N));
    instValid = 0; reqReady = 0;
    for (int k = 0; k < N; k++) begin
      int ix;
      ix = (k * 3 + off) % N;
      rspValid = 1; rspIdx = IW'(ix); rspData = data[ix*MEM_W +: MEM_W];
      @(negedge clk);
      check(!wbValid && !storeDone, "R8 no early completion",
            VLEN'({wbValid, storeDone}), 0);
      check(!reqValid, "R5 no request from ignored instruction", VLEN'(reqValid), 0);
      @(posedge clk); #1;
    end
    rspValid = 0;
    @(negedge clk);
    if (st) begin
      check(storeDone && !wbValid, "R9 store done", VLEN'({storeDone, wbValid}), 2);
    end else begin
      check(wbValid && !storeDone, "R8 writeback", VLEN'({wbValid, storeDone}), 2);
      check(wbData == data, "R7 gathered data", wbData, data);
      check(wbDest == dest, "R8 dest tag", VLEN'(wbDest), VLEN'(dest));
    end
    @(posedge clk); #1;
    @(negedge clk);
    check(!wbValid && !storeDone, "R8 R9 single pulse", VLEN'({wbValid, storeDone}), 0);
    check(instReady == 1'b1, "R5 ready after finish", VLEN'(instReady), 1);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    check(1'b0, "watchdog", 0, 1);
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    logic [VLEN-1:0] pat;
    repeat (3) @(posedge clk);
    #1 rst = 0;
    @(negedge clk);
    check(instReady && !reqValid && !wbValid && !storeDone, "R1 reset state",
          VLEN'({instReady, reqValid, wbValid, storeDone}), VLEN'(4'b1000));

    pat = {8{32'hA5A50000}} ^ {32'd7, 32'd6, 32'd5, 32'd4, 32'd3, 32'd2, 32'd1, 32'd0};
    runInst(1'b0, 32'h0000_1000, 5'd3, pat, 1'b0, 5);
    pat = {32'h11111111, 32'h22222222, 32'h33333333, 32'h44444444,
           32'h55555555, 32'h66666666, 32'h77777777, 32'h88888888};
    runInst(1'b1, 32'h0000_2040, 5'd9, pat, 1'b1, 2);
    pat = {4{64'hDEADBEEF_CAFEF00D}};
    runInst(1'b0, 32'hFFFF_FFF0, 5'd31, pat, 1'b1, 1);
    runInst(1'b1, 32'h0000_0000, 5'd0, ~pat, 1'b0, 7);

    // R10: reset in the middle of an instruction
    @(posedge clk); #1;
    instValid = 1; instIsStore = 0; instBase = 32'h3000; instDest = 5'd4; instStoreData = '0;
    for (int i = 0; i < N; i++)
      expQ.push_back('{32'h3000 + ADDR_W'(i * (MEM_W / 8)), IW'(i), 1'b0, '0});
    @(posedge clk); #1;
    instValid = 0; reqReady = 1;
    repeat (3) @(posedge clk);
    #1 reqReady = 0; rst = 1;
    expQ.delete();
    @(posedge clk); #1 rst = 0;
    @(negedge clk);
    check(instReady && !reqValid, "R10 abandon on reset", VLEN'({instReady, reqValid}), 2);
    pat = {8{32'h0F0F1234}};
    runInst(1'b0, 32'h0000_4000, 5'd12, pat, 1'b0, 3);

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule